// File: doc/BRIEF.md
# Dual-Carrier Asymmetric Gate Pattern Generator

This block produces the four switch drive bits for a three-level converter that shapes line current and regulates its output from a single power stage. It runs two digital sawtooth carriers of equal period, the second offset by half a period, and forms a mirrored copy of the offset carrier. Two unsigned duty commands come from outside loops. One command sets the output transfer and the other sets the bus and current shaping. The block compares these commands, and a fixed inner-switch duty, against the carriers to form the gate pattern.

Duty commands are scaled so that the carrier period `PERIOD` in clock cycles stands for full scale. For example, 5000 counts at 100 MHz gives a 20 kHz switching rate. Both commands are captured only at the start of each main-carrier period, so a command that changes mid-period never cuts a pulse short. A one-cycle strobe marks each period start, and external loop logic can use it to pace its updates. Gates come straight from registers, and the bench counts cycles from the release of reset.

Top module: `sspfc_gate_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all four gate bits and `period_start_o` are low after that edge. Both carriers restart: the main carrier at 0 and the offset carrier at `PERIOD/2`. Both captured duties are cleared to 0.
- R2: After reset is released, the main carrier advances by one each cycle through 0 to `PERIOD-1` and wraps. The offset carrier always equals the main carrier plus `PERIOD/2`, taken modulo `PERIOD`. `period_start_o` is high for exactly the one cycle in which the main carrier is 0, and is never high for the reset state.
- R3: `gate_o[0]` is high exactly when the captured output duty is greater than the main carrier value.
- R4: `gate_o[1]` is high exactly when `FIXED_DUTY` (default 45% of `PERIOD`) is greater than the main carrier. `gate_o[2]` is high exactly when `FIXED_DUTY` is greater than the offset carrier.
- R5: `gate_o[3]` is the OR of two terms. The first is true when the captured output duty is greater than the offset carrier. The second is true when the captured bus duty is greater than `PERIOD-1` minus the offset carrier.
- R6: The duty inputs are captured only on the edge at which the main carrier wraps to 0. Changes at any other cycle have no effect on the gates until the next wrap.
- R7: A captured output duty is limited to `D1_CAP` (default `PERIOD/2`), and a captured bus duty is limited to `PERIOD`. A bus duty at or above `PERIOD` keeps its term of `gate_o[3]` high for the whole period.
- R8: A zero duty makes the gate terms it drives stay low for the whole period. With both duties zero, `gate_o[0]` and `gate_o[3]` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_out_i | input | DW | Output-regulation duty command, unsigned, full scale = PERIOD |
| duty_bus_i | input | DW | Bus-regulation duty command, unsigned, full scale = PERIOD |
| gate_o | output | 4 | Gate bits, bit 0 = first switch through bit 3 = fourth switch |
| period_start_o | output | 1 | One-cycle strobe when the main carrier is at 0 |

## Verification
The bench first holds both duties at zero. This separates the fixed-duty inner gates from the command-driven outer gates. It then holds both duties far above full scale, which shows whether clamping happens and whether it uses the right limit for each command. Random duties are then changed on every cycle. Any capture outside the wrap cycle, or any mix-up between the main and offset carriers or the mirrored carrier, shows up as a wrong edge position. A reset in the middle of a period checks that both carriers restart at their proper phase origins.

// File: rtl/sspfc_pwm_pkg.sv
package sspfc_pwm_pkg;

   // Gate bit positions
   localparam int unsigned GATE_HI_A  = 0;
   localparam int unsigned GATE_MID_A = 1;
   localparam int unsigned GATE_MID_B = 2;
   localparam int unsigned GATE_HI_B  = 3;
   localparam int unsigned NUM_GATES  = 4;

   // Clamp an unsigned value to a ceiling
   function automatic int unsigned clamp_u(input int unsigned v, input int unsigned lim);
      return (v > lim) ? lim : v;
   endfunction

endpackage

// File: rtl/sspfc_ramp.sv
module sspfc_ramp #(
   parameter int unsigned PERIOD = 5000,
   parameter int unsigned CW     = 13,
   parameter int unsigned START  = 0
) (
   input  logic          clk,
   input  logic          rst,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] cnt_nxt_o
);
   localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
   localparam logic [CW-1:0] ORIGIN = CW'(START);

   logic [CW-1:0] cnt_q;

   always_comb begin
      if (rst)
         cnt_nxt_o = ORIGIN;
      else if (cnt_q == LAST)
         cnt_nxt_o = '0;
      else
         cnt_nxt_o = cnt_q + 1'b1;
   end

   always_ff @(posedge clk)
      cnt_q <= cnt_nxt_o;

   assign cnt_o = cnt_q;
endmodule

// File: rtl/sspfc_duty_hold.sv
module sspfc_duty_hold #(
   parameter int unsigned DW    = 16,
   parameter int unsigned CW    = 13,
   parameter int unsigned LIMIT = 2500
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_i,
   input  logic [DW-1:0] duty_i,
   output logic [CW-1:0] q_o,
   output logic [CW-1:0] q_nxt_o
);
   import sspfc_pwm_pkg::*;

   logic [CW-1:0] q_r;
   logic [CW-1:0] sat;

   always_comb begin
      sat = CW'(clamp_u(32'(duty_i), LIMIT));
      if (rst)
         q_nxt_o = '0;
      else if (load_i)
         q_nxt_o = sat;
      else
         q_nxt_o = q_r;
   end

   always_ff @(posedge clk)
      q_r <= q_nxt_o;

   assign q_o = q_r;
endmodule

// File: rtl/sspfc_cmp.sv
module sspfc_cmp #(
   parameter int unsigned CW = 13
) (
   input  logic [CW-1:0] duty_i,
   input  logic [CW-1:0] carrier_i,
   output logic          pulse_o
);
   assign pulse_o = (duty_i > carrier_i);
endmodule

// File: rtl/sspfc_gate_gen.sv
module sspfc_gate_gen #(
   parameter int unsigned PERIOD     = 5000,
   parameter int unsigned DW         = 16,
   parameter int unsigned FIXED_DUTY = (PERIOD * 45) / 100,
   parameter int unsigned D1_CAP     = PERIOD / 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] duty_out_i,
   input  logic [DW-1:0] duty_bus_i,
   output logic [3:0]    gate_o,
   output logic          period_start_o
);
   import sspfc_pwm_pkg::*;

   localparam int unsigned CW     = $clog2(PERIOD + 1);
   localparam int unsigned HALF   = PERIOD / 2;
   localparam int unsigned NCMP   = 5;
   localparam logic [CW-1:0] TOP  = CW'(PERIOD - 1);
   localparam logic [CW-1:0] FIXV = CW'(FIXED_DUTY);

   // Elaboration-time parameter checks
   if (PERIOD < 4) begin : g_chk_period
      $error("PERIOD must be at least 4");
   end
   if (FIXED_DUTY > PERIOD) begin : g_chk_fixed
      $error("FIXED_DUTY exceeds PERIOD");
   end
   if (D1_CAP > PERIOD) begin : g_chk_cap
      $error("D1_CAP exceeds PERIOD");
   end
   if (DW < 1 || DW > 32) begin : g_chk_dw
      $error("DW must be 1..32");
   end

   // Carriers: index 0 main, index 1 offset by half a period
   logic [CW-1:0] car   [2];
   logic [CW-1:0] car_n [2];

   for (genvar p = 0; p < 2; p++) begin : g_ramp
      sspfc_ramp #(
         .PERIOD (PERIOD),
         .CW     (CW),
         .START  (p * HALF)
      ) u_ramp (
         .clk       (clk),
         .rst       (rst),
         .cnt_o     (car[p]),
         .cnt_nxt_o (car_n[p])
      );
   end

   logic          wrap_n;
   logic [CW-1:0] d1_lat, d1_n;
   logic [CW-1:0] d2_lat, d2_n;
   logic [CW-1:0] mirror_n;

   assign wrap_n   = !rst && (car_n[0] == '0);
   assign mirror_n = TOP - car_n[1];

   sspfc_duty_hold #(.DW(DW), .CW(CW), .LIMIT(D1_CAP)) u_hold_out (
      .clk     (clk),
      .rst     (rst),
      .load_i  (wrap_n),
      .duty_i  (duty_out_i),
      .q_o     (d1_lat),
      .q_nxt_o (d1_n)
   );

   sspfc_duty_hold #(.DW(DW), .CW(CW), .LIMIT(PERIOD)) u_hold_bus (
      .clk     (clk),
      .rst     (rst),
      .load_i  (wrap_n),
      .duty_i  (duty_bus_i),
      .q_o     (d2_lat),
      .q_nxt_o (d2_n)
   );

   // Comparator pairs evaluated on next-state values so gates register in step with carriers
   logic [CW-1:0] cmp_duty [NCMP];
   logic [CW-1:0] cmp_car  [NCMP];
   logic [NCMP-1:0] cmp_hit;

   always_comb begin
      cmp_duty[0] = d1_n;  cmp_car[0] = car_n[0];
      cmp_duty[1] = FIXV;  cmp_car[1] = car_n[0];
      cmp_duty[2] = FIXV;  cmp_car[2] = car_n[1];
      cmp_duty[3] = d1_n;  cmp_car[3] = car_n[1];
      cmp_duty[4] = d2_n;  cmp_car[4] = mirror_n;
   end

   for (genvar c = 0; c < NCMP; c++) begin : g_cmp
      sspfc_cmp #(.CW(CW)) u_cmp (
         .duty_i    (cmp_duty[c]),
         .carrier_i (cmp_car[c]),
         .pulse_o   (cmp_hit[c])
      );
   end

   logic [NUM_GATES-1:0] gate_n;
   always_comb begin
      gate_n             = '0;
      gate_n[GATE_HI_A]  = cmp_hit[0];
      gate_n[GATE_MID_A] = cmp_hit[1];
      gate_n[GATE_MID_B] = cmp_hit[2];
      gate_n[GATE_HI_B]  = cmp_hit[3] | cmp_hit[4];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gate_o         <= '0;
         period_start_o <= 1'b0;
      end else begin
         gate_o         <= gate_n;
         period_start_o <= wrap_n;
      end
   end
endmodule

// File: rtl/sspfc_gate_gen_chk.sv
module sspfc_gate_gen_chk #(
   parameter int unsigned PERIOD = 5000,
   parameter int unsigned D1_CAP = PERIOD / 2,
   parameter int unsigned CW     = 13
) (
   input logic          clk,
   input logic          rst,
   input logic [3:0]    gate_o,
   input logic          period_start_o,
   input logic [CW-1:0] main_car,
   input logic [CW-1:0] offs_car,
   input logic [CW-1:0] d1_lat,
   input logic [CW-1:0] d2_lat
);
   localparam int unsigned HALF = PERIOD / 2;

   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (gate_o == 4'b0 && !period_start_o)); // R1
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) period_start_o |=> !period_start_o); // R2
   AST_CARRIER_OFFSET: assert property (@(posedge clk) disable iff (rst)
      32'(offs_car) == ((32'(main_car) + HALF) % PERIOD)); // R2
   AST_DUTY_HELD: assert property (@(posedge clk) disable iff (rst)
      (!rst && !period_start_o && !$past(rst)) |-> ($stable(d1_lat) && $stable(d2_lat))); // R6
   AST_D1_LIMIT: assert property (@(posedge clk) disable iff (rst) 32'(d1_lat) <= D1_CAP); // R7
   AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
      (d1_lat == '0 && d2_lat == '0) |-> (!gate_o[0] && !gate_o[3])); // R8
endmodule

bind sspfc_gate_gen sspfc_gate_gen_chk #(
   .PERIOD (PERIOD),
   .D1_CAP (D1_CAP),
   .CW     (CW)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .gate_o         (gate_o),
   .period_start_o (period_start_o),
   .main_car       (car[0]),
   .offs_car       (car[1]),
   .d1_lat         (d1_lat),
   .d2_lat         (d2_lat)
);

// File: tb/sspfc_gate_gen_test.sv
module sspfc_gate_gen_test;
   localparam int unsigned P    = 40;
   localparam int unsigned DW   = 8;
   localparam int unsigned FIX  = 18;
   localparam int unsigned CAP  = 20;
   localparam int unsigned HALF = P / 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] duty_out_i = '0;
   logic [DW-1:0] duty_bus_i = '0;
   logic [3:0]    gate_o;
   logic          period_start_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Bench reference state
   int unsigned m_main, m_offs, m_d1, m_d2;
   bit          m_rst;

   always #5 clk = ~clk;

   sspfc_gate_gen #(
      .PERIOD     (P),
      .DW         (DW),
      .FIXED_DUTY (FIX),
      .D1_CAP     (CAP)
   ) uut (
      .clk            (clk),
      .rst            (rst),
      .duty_out_i     (duty_out_i),
      .duty_bus_i     (duty_bus_i),
      .gate_o         (gate_o),
      .period_start_o (period_start_o)
   );

   function automatic int unsigned lim(input int unsigned v, input int unsigned c);
      return (v > c) ? c : v;
   endfunction

   function automatic logic [3:0] exp_gates(input int unsigned mc, input int unsigned oc,
                                            input int unsigned d1, input int unsigned d2);
      logic [3:0] g;
      g[0] = d1 > mc;
      g[1] = FIX > mc;
      g[2] = FIX > oc;
      g[3] = (d1 > oc) || (d2 > (P - 1 - oc));
      return g;
   endfunction

   task automatic check_bit(input string tag, input string req, input logic act, input logic expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL [%s] %s: actual %b expected %b at %0t", tag, req, act, expv, $time);
      end
   endtask

   // One clock: update reference at the edge, compare at the falling edge
   task automatic step(input string tag);
      logic [3:0] eg;
      logic       es;
      @(posedge clk);
      if (rst) begin
         m_rst = 1'b1; m_main = 0; m_offs = HALF; m_d1 = 0; m_d2 = 0;
         eg = 4'b0; es = 1'b0;
      end else begin
         m_rst  = 1'b0;
         m_main = (m_main + 1) % P;
         m_offs = (m_offs + 1) % P;
         if (m_main == 0) begin
            m_d1 = lim(duty_out_i, CAP);
            m_d2 = lim(duty_bus_i, P);
         end
         eg = exp_gates(m_main, m_offs, m_d1, m_d2);
         es = (m_main == 0);
      end
      @(negedge clk);
      if (m_rst) begin
         check_bit(tag, "R1 gates", |gate_o, 1'b0);
         check_bit(tag, "R1 strobe", period_start_o, 1'b0);
      end else begin
         check_bit(tag, "R3 gate0", gate_o[0], eg[0]);
         check_bit(tag, "R4 gate1", gate_o[1], eg[1]);
         check_bit(tag, "R4 gate2", gate_o[2], eg[2]);
         check_bit(tag, "R5 gate3", gate_o[3], eg[3]);
         check_bit(tag, "R2 strobe", period_start_o, es);
      end
   endtask

   initial begin
      void'($urandom(32'd1357));
      rst = 1'b1;
      repeat (3) step("R1 reset");
      @(negedge clk) rst = 1'b0;

      // R8: zero duties, only the fixed inner gates toggle
      repeat (2 * P) step("R8 zero duty");

      // R7: far above full scale on both commands
      duty_out_i = 8'd255; duty_bus_i = 8'd255;
      repeat (3 * P) step("R7 saturation");

      // R6: set duties, then change them mid-period
      duty_out_i = 8'd12; duty_bus_i = 8'd9;
      repeat (P) step("R6 capture");
      repeat (P / 3) step("R6 hold");
      duty_out_i = 8'd3; duty_bus_i = 8'd33;
      repeat (2 * P) step("R6 mid-change");

      // Exact limit values
      duty_out_i = 8'(CAP); duty_bus_i = 8'(P);
      repeat (2 * P) step("R7 limit");

      // Mid-period reset: R1 then R2 carrier restart
      repeat (7) step("R2 run");
      rst = 1'b1;
      repeat (2) step("R1 mid reset");
      @(negedge clk) rst = 1'b0;
      repeat (2 * P) step("R2 restart");

      // Random duties changing every cycle
      for (int i = 0; i < 60 * P; i++) begin
         duty_out_i = DW'($urandom_range(0, 60));
         duty_bus_i = DW'($urandom_range(0, 60));
         step("R5 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL [watchdog] R1 run did not end: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule